// File: doc/BRIEF.md
# BCD Timekeeper Register Window

This block keeps calendar time in packed BCD counters and advances them on a one-cycle tick pulse that arrives once per second. The counters cover seconds, minutes, hours, day of week, day of month, month, two-digit year and a century flag. Software reaches them through eight byte registers on a plain synchronous bus. Writes take effect on the clock edge, and read data follows the address combinationally.

Register 0 holds control. Bit 7 opens a loading session: time-register writes go to a staging copy, and clearing the bit commits the whole copy to the counters on one edge. Bit 6 freezes a snapshot, so a multi-byte read is coherent while the counters keep running underneath. A control state machine tracks these bits. It has three states: `ST_LIVE` (reads show the counters), `ST_FROZEN` (reads show the snapshot) and `ST_LOADING` (reads show the staging copy). Its transitions are:
- `ST_LIVE` to `ST_LOADING` (bit 7 written 1; the staging copy is taken from the counters).
- `ST_LIVE` to `ST_FROZEN` (bit 6 written 1 with bit 7 at 0; the snapshot is taken from the counters).
- `ST_FROZEN` to `ST_LOADING` (bit 7 written 1).
- `ST_FROZEN` to `ST_LIVE` (bit 6 written 0).
- `ST_LOADING` to `ST_LIVE` (bit 7 written 0 with bit 6 at 0; commit).
- `ST_LOADING` to `ST_FROZEN` (bit 7 written 0 with bit 6 at 1; commit, with the snapshot taken from the committed values).

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset every one of the eight registers reads 0x00.
- R2: Control bits 5:0 read back as last written and have no effect on timekeeping. Offset 0 reads the whole control byte.
- R3: Seconds and minutes wrap from 59 to 00, and each wrap carries into the next field. Hours wrap from 23 to 00.
- R4: The weekday field (offset 4, bits 2:0) advances at midnight and wraps from 7 to 1.
- R5: The date (offset 5, bits 5:0) wraps to 01 after the last day of the month, using lengths of 30 days for months 04, 06, 09 and 11 and 31 days for the other non-February months. The month (offset 6, bits 4:0) wraps from 12 to 01 and increments the year (offset 7).
- R6: February ends on 29 when the BCD year is divisible by 4, and on 28 otherwise.
- R7: On the year wrap from 99 to 00, the century flag (offset 4, bit 4) inverts only if century enable (offset 4, bit 5) is 1. Otherwise it keeps its value.
- R8: While the stop flag (offset 1, bit 7) is 1, ticks do not change any time field.
- R9: While control bit 6 is 1, reads of offsets 1 to 7 return the values captured when the bit was set. Ticks during that time still advance the counters, and clearing the bit shows the advanced time.
- R10: Writes to offsets 1 to 7 are ignored unless control bit 7 is 1. While bit 7 is 1, those writes read back at once, and clearing bit 7 commits all fields in one edge.
- R11: Field layout: offset 1 = {stop, sec[6:0]}, offset 2 = {0, min[6:0]}, offset 3 = {00, hour[5:0]}, offset 4 = {0, ftest, cen_en, cent, 0, wday[2:0]}, offset 5 = {00, date[5:0]}, offset 6 = {000, month[4:0]}, offset 7 = year[7:0]. Unmapped bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse that advances time by one second |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |

## Verification
A wrong carry decision shows at the ports on the very tick that crosses the boundary: a field that fails to clear, or the next field failing to step. The checks therefore load times one second before each boundary and read every affected offset just after the tick. A state machine that disagrees with the control bits shows up in the first read after the control write, because the wrong copy (live, snapshot or staging) is returned. A lost tick during a freeze shows up in the first read after the freeze is released.

// File: rtl/tk_pkg.sv
package tk_pkg;

    localparam int TK_ADDR_W = 3;
    localparam int TK_DATA_W = 8;

    typedef struct packed {
        logic       stop;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       ftest;
        logic       cen_en;
        logic       cent;
        logic [2:0] wday;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
    } tk_time_t;

    typedef enum logic [1:0] {
        ST_LIVE    = 2'd0,
        ST_FROZEN  = 2'd1,
        ST_LOADING = 2'd2
    } tk_state_e;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    function automatic logic leap_year(input logic [7:0] y);
        logic [7:0] bin;
        bin = ({4'h0, y[7:4]} * 8'd10) + {4'h0, y[3:0]};
        return (bin[1:0] == 2'b00);
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
        unique case (m)
            5'h02:                      return leap_year(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    function automatic tk_time_t field_write(input tk_time_t t, input logic [TK_ADDR_W-1:0] a,
                                             input logic [TK_DATA_W-1:0] d);
        tk_time_t r;
        r = t;
        unique case (a)
            3'd1: begin r.stop = d[7]; r.sec = d[6:0]; end
            3'd2: r.min = d[6:0];
            3'd3: r.hour = d[5:0];
            3'd4: begin r.ftest = d[6]; r.cen_en = d[5]; r.cent = d[4]; r.wday = d[2:0]; end
            3'd5: r.date = d[5:0];
            3'd6: r.month = d[4:0];
            3'd7: r.year = d;
            default: r = t;
        endcase
        return r;
    endfunction

    function automatic logic [TK_DATA_W-1:0] field_read(input tk_time_t t, input logic [TK_ADDR_W-1:0] a);
        unique case (a)
            3'd1:    return {t.stop, t.sec};
            3'd2:    return {1'b0, t.min};
            3'd3:    return {2'b00, t.hour};
            3'd4:    return {1'b0, t.ftest, t.cen_en, t.cent, 1'b0, t.wday};
            3'd5:    return {2'b00, t.date};
            3'd6:    return {3'b000, t.month};
            3'd7:    return t.year;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/tk_rollover.sv
module tk_rollover
    import tk_pkg::*;
(
    input  tk_time_t cur,
    output tk_time_t nxt
);
    logic [7:0] sec_i, min_i, hour_i, date_i, mon_i, year_i;
    logic [5:0] last_day;

    always_comb begin
        sec_i    = bcd_inc({1'b0, cur.sec});
        min_i    = bcd_inc({1'b0, cur.min});
        hour_i   = bcd_inc({2'b00, cur.hour});
        date_i   = bcd_inc({2'b00, cur.date});
        mon_i    = bcd_inc({3'b000, cur.month});
        year_i   = bcd_inc(cur.year);
        last_day = month_last(cur.month, cur.year);

        nxt = cur;
        if (cur.sec >= 7'h59) begin
            nxt.sec = '0;
            if (cur.min >= 7'h59) begin
                nxt.min = '0;
                if (cur.hour >= 6'h23) begin
                    nxt.hour = '0;
                    nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
                    if (cur.date >= last_day) begin
                        nxt.date = 6'h01;
                        if (cur.month >= 5'h12) begin
                            nxt.month = 5'h01;
                            if (cur.year >= 8'h99) begin
                                nxt.year = '0;
                                nxt.cent = cur.cent ^ cur.cen_en;
                            end else begin
                                nxt.year = year_i;
                            end
                        end else begin
                            nxt.month = mon_i[4:0];
                        end
                    end else begin
                        nxt.date = date_i[5:0];
                    end
                end else begin
                    nxt.hour = hour_i[5:0];
                end
            end else begin
                nxt.min = min_i[6:0];
            end
        end else begin
            nxt.sec = sec_i[6:0];
        end
    end
endmodule

// File: rtl/tk_ctrl_fsm.sv
module tk_ctrl_fsm
    import tk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_wr,
    input  logic      want_load,
    input  logic      want_freeze,
    output tk_state_e state,
    output logic      cap_stage,
    output logic      cap_snap,
    output logic      snap_src_stage,
    output logic      commit
);
    tk_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LIVE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx       = state;
        cap_stage      = 1'b0;
        cap_snap       = 1'b0;
        snap_src_stage = 1'b0;
        commit         = 1'b0;
        unique case (state)
            ST_LIVE: if (ctrl_wr) begin
                if (want_load) begin
                    state_nx  = ST_LOADING;
                    cap_stage = 1'b1;
                end else if (want_freeze) begin
                    state_nx = ST_FROZEN;
                    cap_snap = 1'b1;
                end
            end
            ST_FROZEN: if (ctrl_wr) begin
                if (want_load) begin
                    state_nx  = ST_LOADING;
                    cap_stage = 1'b1;
                end else if (!want_freeze) begin
                    state_nx = ST_LIVE;
                end
            end
            ST_LOADING: if (ctrl_wr && !want_load) begin
                commit = 1'b1;
                if (want_freeze) begin
                    state_nx       = ST_FROZEN;
                    cap_snap       = 1'b1;
                    snap_src_stage = 1'b1;
                end else begin
                    state_nx = ST_LIVE;
                end
            end
            default: state_nx = ST_LIVE;
        endcase
    end

    // R10
    cap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_stage, commit}));
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
    import tk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_1hz,
    input  logic [TK_ADDR_W-1:0] bus_addr,
    input  logic                 bus_we,
    input  logic [TK_DATA_W-1:0] bus_wdata,
    output logic [TK_DATA_W-1:0] bus_rdata
);
    localparam logic [TK_ADDR_W-1:0] CTRL_OFS = '0;

    logic [TK_DATA_W-1:0] ctrl_q;
    tk_time_t             live_q, stage_q, snap_q, live_nx;
    tk_state_e            state;
    logic                 ctrl_wr, cap_stage, cap_snap, snap_src_stage, commit;

    assign ctrl_wr = bus_we && (bus_addr == CTRL_OFS);

    tk_ctrl_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctrl_wr        (ctrl_wr),
        .want_load      (bus_wdata[7]),
        .want_freeze    (bus_wdata[6]),
        .state          (state),
        .cap_stage      (cap_stage),
        .cap_snap       (cap_snap),
        .snap_src_stage (snap_src_stage),
        .commit         (commit)
    );

    tk_rollover u_roll (
        .cur (live_q),
        .nxt (live_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            live_q  <= '0;
            stage_q <= '0;
            snap_q  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= bus_wdata;
            if (commit)                        live_q <= stage_q;
            else if (tick_1hz && !live_q.stop) live_q <= live_nx;
            if (cap_stage)
                stage_q <= live_q;
            else if (state == ST_LOADING && bus_we && bus_addr != CTRL_OFS)
                stage_q <= field_write(stage_q, bus_addr, bus_wdata);
            if (cap_snap) snap_q <= snap_src_stage ? stage_q : live_q;
        end
    end

    always_comb begin
        if (bus_addr == CTRL_OFS) bus_rdata = ctrl_q;
        else begin
            unique case (state)
                ST_FROZEN:  bus_rdata = field_read(snap_q, bus_addr);
                ST_LOADING: bus_rdata = field_read(stage_q, bus_addr);
                default:    bus_rdata = field_read(live_q, bus_addr);
            endcase
        end
    end

    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q.stop && !commit) |=> $stable(live_q));
    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FROZEN) |=> $stable(snap_q));
    // R10
    ctrl_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOADING) == ctrl_q[7]);
    // R3
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !live_q.stop && !commit && live_q.sec == 7'h59) |=> (live_q.sec == 7'h00));
    // R7
    cent_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !live_q.cen_en) |=> (live_q.cent == $past(live_q.cent)));
endmodule

// File: tb/bcd_timekeeper_bench.sv
module bcd_timekeeper_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    bcd_timekeeper u_bcd_timekeeper (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        n_vec++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s offset %0d: got %02h expected %02h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic load(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                        input logic [7:0] y, input logic [7:0] ctrl_end);
        wr(0, 8'h80);
        wr(1, s); wr(2, m); wr(3, h); wr(4, w); wr(5, d); wr(6, mo); wr(7, y);
        wr(0, ctrl_end);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) chk("R1", 3'(a), 8'h00);
    endtask

    task automatic t_ctrl_store();
        wr(0, 8'h2A);
        chk("R2", 0, 8'h2A);
        tick();
        chk("R2", 1, 8'h01);
        wr(0, 8'h00);
    endtask

    task automatic t_ignored_write();
        wr(2, 8'h33);
        chk("R10", 2, 8'h00);
        wr(0, 8'h80);
        wr(4, 8'hFF);
        chk("R11", 4, 8'h77);
        wr(1, 8'h58);
        chk("R10", 1, 8'h58);
        wr(0, 8'h00);
    endtask

    task automatic t_full_roll();
        load(8'h58, 8'h59, 8'h23, 8'h27, 8'h31, 8'h12, 8'h99, 8'h00);
        chk("R10", 1, 8'h58);
        chk("R10", 7, 8'h99);
        tick();
        chk("R3", 1, 8'h59);
        tick();
        chk("R3", 1, 8'h00);
        chk("R3", 2, 8'h00);
        chk("R3", 3, 8'h00);
        chk("R4", 4, 8'h31);
        chk("R5", 5, 8'h01);
        chk("R5", 6, 8'h01);
        chk("R7", 7, 8'h00);
    endtask

    task automatic t_cent_disabled();
        load(8'h59, 8'h59, 8'h23, 8'h17, 8'h31, 8'h12, 8'h99, 8'h00);
        tick();
        chk("R7", 4, 8'h11);
        chk("R7", 7, 8'h00);
    endtask

    task automatic t_months();
        load(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h00);
        tick();
        chk("R6", 5, 8'h29);
        chk("R6", 6, 8'h02);
        chk("R4", 4, 8'h04);
        load(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23, 8'h00);
        tick();
        chk("R6", 5, 8'h01);
        chk("R6", 6, 8'h03);
        load(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h10, 8'h00);
        tick();
        chk("R5", 5, 8'h01);
        chk("R5", 6, 8'h05);
        load(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h05, 8'h10, 8'h00);
        tick();
        chk("R5", 5, 8'h31);
        chk("R5", 6, 8'h05);
    endtask

    task automatic t_minute_carry();
        load(8'h59, 8'h34, 8'h12, 8'h02, 8'h10, 8'h06, 8'h05, 8'h00);
        tick();
        chk("R3", 1, 8'h00);
        chk("R3", 2, 8'h35);
        chk("R3", 3, 8'h12);
    endtask

    task automatic t_stop();
        load(8'h90, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00);
        tick(); tick(); tick();
        chk("R8", 1, 8'h90);
        chk("R8", 2, 8'h00);
    endtask

    task automatic t_freeze();
        load(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00);
        wr(0, 8'h40);
        tick(); tick();
        chk("R9", 1, 8'h10);
        chk("R9", 0, 8'h40);
        wr(0, 8'h00);
        chk("R9", 1, 8'h12);
    endtask

    task automatic t_commit_freeze();
        load(8'h07, 8'h06, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00, 8'h40);
        chk("R9", 1, 8'h07);
        tick();
        chk("R9", 1, 8'h07);
        wr(0, 8'h00);
        chk("R10", 1, 8'h08);
        chk("R10", 2, 8'h06);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_store();
        t_ignored_write();
        t_full_roll();
        t_cent_disabled();
        t_months();
        t_minute_carry();
        t_stop();
        t_freeze();
        t_commit_freeze();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule